// File: doc/BRIEF.md
# Bus Port Quiesce Handshake Controller

This controller brings a single bus port to a quiet state before the surrounding logic removes its power or applies a reset. A one-cycle start pulse launches the sequence. If the port already reports idle, the controller finishes at once and never raises a halt request. Otherwise it raises a halt request and polls the port's acknowledge on every timebase tick. The wait ends when an acknowledge is seen or when a tick budget runs out. The controller then samples idle a second time, drops the request whatever the outcome, and pulses done. A failure flag is set if the port was still busy at that second sample. Dropping the request is safe because a port that has halted stays halted until it is reset.

All pins are plain control and status lines, so no data stream and no back-pressure are involved. The tick input is a slow timebase strobe, such as one pulse per millisecond. The `TIMEOUT_TICKS` parameter sets the wait budget in ticks and defaults to 100. Each instance serves one port.

Top module: `port_quiesce_ctrl`

## Requirements
- R1: After reset, `halt_req_o`, `done_o` and `fail_o` are all low.
- R2: A start seen while the controller is waiting and `port_idle_i` is high makes `done_o` high in the next cycle. `halt_req_o` stays low throughout and `fail_o` is low.
- R3: A start seen while the controller is waiting and `port_idle_i` is low makes `halt_req_o` high from the next cycle. It stays high for the whole acknowledge wait.
- R4: The acknowledge is acted on only in a cycle where `tick_i` is high. An acknowledge held between ticks does not end the wait.
- R5: If no acknowledge is seen on `TIMEOUT_TICKS` consecutive ticks, the wait ends on the last of those ticks.
- R6: The wait ends on a tick edge. Exactly one cycle after that edge, `port_idle_i` is sampled again and `fail_o` takes its inverse. `fail_o` holds that value until the next accepted start, which clears it.
- R7: `halt_req_o` falls in the same cycle that `done_o` rises, whether the wait ended by acknowledge or by timeout.
- R8: `done_o` is high for exactly one cycle per completed sequence.
- R9: A start pulse that arrives while a sequence is in progress is ignored. It does not restart, lengthen or repeat the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to quiesce the port |
| port_idle_i | input | 1 | Port reports no outstanding traffic |
| halt_ack_i | input | 1 | Port acknowledges the halt request |
| tick_i | input | 1 | Timebase strobe that paces polling and the timeout |
| halt_req_o | output | 1 | Halt request to the port |
| done_o | output | 1 | One-cycle pulse when the sequence ends |
| fail_o | output | 1 | Port was not idle at the final check |

## Verification
The hardest case is a timeout in which the port stays busy. It needs a long run of ticks with no acknowledge, followed by a low idle at exactly the final-check cycle. The bench uses a small tick budget and spaces its tick pulses apart. It confirms that the request is still held one tick before the budget runs out. It then holds idle low through the last tick so that the failure flag must be raised. A separate scenario keeps the acknowledge high for several cycles with no tick and injects a start pulse mid-wait, to show that neither one moves the sequence.

// File: rtl/pq_pkg.sv
package pq_pkg;
  typedef enum logic [1:0] {
    PQ_IDLE = 2'd0,
    PQ_WAIT = 2'd1,
    PQ_FIN  = 2'd2
  } pq_state_t;
endpackage

// File: rtl/pq_tick_timer.sv
module pq_tick_timer #(
  parameter int TIMEOUT_TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int CNT_W = (TIMEOUT_TICKS < 2) ? 1 : $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (tick_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = tick_i && (cnt_q == LAST);

  // R5: the tick count never runs past the budget
  a_r5_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/pq_seq_fsm.sv
module pq_seq_fsm
  import pq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic port_idle_i,
  input  logic halt_ack_i,
  input  logic tick_i,
  input  logic expire_i,
  output logic timer_clr_o,
  output logic halt_req_o,
  output logic done_o,
  output logic fail_o
);
  pq_state_t state_q;
  logic      leave_wait;

  assign leave_wait  = tick_i && (halt_ack_i || expire_i);
  assign timer_clr_o = (state_q != PQ_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PQ_IDLE;
      halt_req_o <= 1'b0;
      done_o     <= 1'b0;
      fail_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        PQ_IDLE: begin
          if (start_i) begin
            fail_o <= 1'b0;
            if (port_idle_i) begin
              done_o <= 1'b1;
            end else begin
              halt_req_o <= 1'b1;
              state_q    <= PQ_WAIT;
            end
          end
        end
        PQ_WAIT: begin
          if (leave_wait) state_q <= PQ_FIN;
        end
        PQ_FIN: begin
          fail_o     <= !port_idle_i;
          halt_req_o <= 1'b0;
          done_o     <= 1'b1;
          state_q    <= PQ_IDLE;
        end
        default: state_q <= PQ_IDLE;
      endcase
    end
  end

  // R2: an idle port skips the handshake
  a_r2_skip_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PQ_IDLE && start_i && port_idle_i) |=> (done_o && !halt_req_o));
  // R3: request held while waiting
  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PQ_WAIT) |-> halt_req_o);
  // R4: no exit from the wait without a tick
  a_r4_tick_paced: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PQ_WAIT && !tick_i) |=> (state_q == PQ_WAIT));
  // R7: request released when done rises
  a_r7_release_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !halt_req_o);
  // R8: done lasts one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R9: the request rises only from an accepted start
  a_r9_req_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_req_o) |-> $past(start_i));
endmodule

// File: rtl/port_quiesce_ctrl.sv
module port_quiesce_ctrl #(
  parameter int TIMEOUT_TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic port_idle_i,
  input  logic halt_ack_i,
  input  logic tick_i,
  output logic halt_req_o,
  output logic done_o,
  output logic fail_o
);
  logic timer_clr;
  logic expire;

  pq_tick_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (timer_clr),
    .tick_i   (tick_i),
    .expire_o (expire)
  );

  pq_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .port_idle_i (port_idle_i),
    .halt_ack_i  (halt_ack_i),
    .tick_i      (tick_i),
    .expire_i    (expire),
    .timer_clr_o (timer_clr),
    .halt_req_o  (halt_req_o),
    .done_o      (done_o),
    .fail_o      (fail_o)
  );
endmodule

// File: tb/port_quiesce_ctrl_tb.sv
module port_quiesce_ctrl_tb;
  localparam int TO = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, port_idle_i = 1'b0, halt_ack_i = 1'b0, tick_i = 1'b0;
  logic halt_req_o, done_o, fail_o;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  port_quiesce_ctrl #(.TIMEOUT_TICKS(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .port_idle_i(port_idle_i),
    .halt_ack_i(halt_ack_i), .tick_i(tick_i),
    .halt_req_o(halt_req_o), .done_o(done_o), .fail_o(fail_o)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start_i = 1'b1; step(); start_i = 1'b0;
  endtask

  task automatic pulse_tick();
    tick_i = 1'b1; step(); tick_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "halt_req", halt_req_o, 1'b0);
    chk("R1", "done", done_o, 1'b0);
    chk("R1", "fail", fail_o, 1'b0);
  endtask

  task automatic t_already_idle();
    port_idle_i = 1'b1;
    pulse_start();
    chk("R2", "done", done_o, 1'b1);
    chk("R2", "halt_req", halt_req_o, 1'b0);
    chk("R2", "fail", fail_o, 1'b0);
    step();
    chk("R8", "done drop", done_o, 1'b0);
    chk("R2", "halt_req after", halt_req_o, 1'b0);
  endtask

  task automatic t_ack_path();
    port_idle_i = 1'b0;
    pulse_start();
    chk("R3", "halt_req up", halt_req_o, 1'b1);
    chk("R3", "done low", done_o, 1'b0);
    halt_ack_i = 1'b1;
    repeat (3) step();
    chk("R4", "ack w/o tick holds req", halt_req_o, 1'b1);
    chk("R4", "ack w/o tick no done", done_o, 1'b0);
    pulse_start(); // R9: ignored while busy
    step();
    chk("R9", "busy start no done", done_o, 1'b0);
    chk("R9", "busy start req held", halt_req_o, 1'b1);
    port_idle_i = 1'b1;
    pulse_tick();
    chk("R6", "check cycle req", halt_req_o, 1'b1);
    chk("R6", "check cycle done", done_o, 1'b0);
    step();
    chk("R7", "done with ack", done_o, 1'b1);
    chk("R7", "req dropped", halt_req_o, 1'b0);
    chk("R6", "fail low when idle", fail_o, 1'b0);
    halt_ack_i = 1'b0;
    step();
    chk("R8", "done one cycle", done_o, 1'b0);
    step();
    chk("R9", "no replay of busy start", halt_req_o, 1'b0);
    chk("R9", "no extra done", done_o, 1'b0);
  endtask

  task automatic t_timeout(logic idle_at_end);
    port_idle_i = 1'b0;
    halt_ack_i = 1'b0;
    pulse_start();
    for (int i = 0; i < TO - 1; i++) begin
      pulse_tick();
      step();
    end
    chk("R5", "req before budget", halt_req_o, 1'b1);
    chk("R5", "no done before budget", done_o, 1'b0);
    port_idle_i = idle_at_end;
    pulse_tick();
    chk("R5", "final check cycle done", done_o, 1'b0);
    step();
    chk("R5", "done on timeout", done_o, 1'b1);
    chk("R7", "req dropped on timeout", halt_req_o, 1'b0);
    chk("R6", "fail = !idle", fail_o, !idle_at_end);
    step();
    chk("R6", "fail held", fail_o, !idle_at_end);
    chk("R8", "done drop", done_o, 1'b0);
  endtask

  task automatic t_fail_clear();
    port_idle_i = 1'b1;
    pulse_start();
    chk("R6", "fail cleared by start", fail_o, 1'b0);
    chk("R2", "done after clear", done_o, 1'b1);
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step();
    t_reset();
    step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_already_idle();
    t_ack_path();
    t_timeout(1'b0);
    t_fail_clear();
    t_timeout(1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule